// File: doc/BRIEF.md
# Transactional Register Checkpoint Manager

This block keeps the speculative register state of an out-of-order core safe while a hardware transaction runs. It owns the architectural-to-physical rename table. The renamer reads it through a registered read port and updates it through a write port. When a transaction opens, the block copies the whole table into a checkpoint and tags every physical register mapped at that moment as saved. While the transaction runs, graduation releases a physical register when its mapping has been overwritten. A saved register that is released in this way is parked in a reserved pool. It does not go back to the free list, because an abort would make it live again.

Nested transactions are flattened. A nesting counter tracks the depth, but only the outermost open takes a checkpoint and records the abort-handler address. Closing the outermost level commits. The reserved registers then move to a drain pool, and the drain pool feeds the free list one register per cycle whenever graduation is not using the push port. An abort at any depth does four things: it restores the checkpointed table, drops the reserved pool, clears the nesting depth and issues a fetch redirect to the recorded handler address.

Top module: `txn_ckpt_mgr`

## Requirements
- R1: After reset the nesting depth is 0, redirect_vld, nest_err and free_vld are 0, and architectural register a maps to physical register a.
- R2: map_rdata presents, one cycle after map_raddr, the entry as it stood before that cycle's update. A write with map_we stores map_wdata at map_waddr unless an abort is taken in the same cycle.
- R3: An open command (xbeg_vld without xabort_vld) at depth 0 increments the depth, copies the table (before that cycle's write) into the checkpoint, records xbeg_pc as the handler address and tags every mapped physical register as saved.
- R4: An open at a depth between 1 and the maximum (2^DEPTH_W-1) only increments the depth. The checkpoint and the handler address are left as they are. An open at the maximum depth is dropped and nest_err pulses one cycle later.
- R5: A release of a saved register is held in the reserved pool and not pushed. Any other release appears on free_vld/free_preg with the same index one cycle later.
- R6: A close command at depth 1 commits. The saved tags clear, and every reserved register (including one released in the commit cycle) is pushed once, lowest index first, in cycles without a direct release. A close at a depth above 1 only decrements the depth.
- R7: An abort at a depth above 0 restores the table from the checkpoint, discards the reserved pool without pushing it, clears the saved tags and sets the depth to 0. One cycle later redirect_vld pulses with redirect_pc equal to the handler address.
- R8: When xabort_vld is high, an open or close command in the same cycle is ignored. When the abort is taken, a table write in that cycle is ignored as well.
- R9: A close at depth 0 (with no open or abort in the same cycle) pulses nest_err one cycle later and changes no state. A close in the same cycle as an open is ignored.
- R10: An abort at depth 0 is ignored and produces no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xbeg_vld | input | 1 | Transaction open command |
| xbeg_pc | input | PC_W | Abort-handler address carried by the open |
| xend_vld | input | 1 | Transaction close command |
| xabort_vld | input | 1 | Transaction abort command |
| map_we | input | 1 | Rename table write enable |
| map_waddr | input | AW | Architectural register to write |
| map_wdata | input | PW | Physical register written |
| map_raddr | input | AW | Architectural register to read |
| map_rdata | output | PW | Registered read data |
| rel_vld | input | 1 | Graduation releases a physical register |
| rel_preg | input | PW | Released physical register |
| free_vld | output | 1 | Push to the free list |
| free_preg | output | PW | Physical register pushed |
| redirect_vld | output | 1 | Fetch redirect after an abort |
| redirect_pc | output | PC_W | Redirect target (handler address) |
| nest_depth | output | DEPTH_W | Current nesting depth |
| nest_err | output | 1 | Unbalanced close or open at maximum depth |

## Verification
A stale or wrong checkpoint shows up as wrong map_rdata on the first read after an abort, which is two cycles after the abort command. A lost or wrong saved tag shows up one cycle after a release, either as a register pushed during a transaction or as a register missing from the free pushes after commit. Aborts discard the reserved pool, so a register pushed after an abort is also a visible fault. The bench therefore keeps a full shadow of the table, checkpoint, tags and pools and compares every port on every cycle.

// File: rtl/txn_ckpt_pkg.sv
package txn_ckpt_pkg;
  // per-cycle decoded control shared between the submodules
  typedef struct packed {
    logic take_ckpt;  // outermost open accepted
    logic commit;     // outermost close accepted
    logic abort_take; // abort accepted at nonzero depth
  } ckpt_ctl_t;
endpackage

// File: rtl/ckpt_nest_ctrl.sv
module ckpt_nest_ctrl
  import txn_ckpt_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int DEPTH_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               beg_i,
  input  logic [PC_W-1:0]    beg_pc_i,
  input  logic               end_i,
  input  logic               abort_i,
  output ckpt_ctl_t          ctl_o,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               redirect_vld_o,
  output logic [PC_W-1:0]    redirect_pc_o,
  output logic               err_o
);
  localparam logic [DEPTH_W-1:0] DMAX = '1;
  localparam logic [DEPTH_W-1:0] DONE = DEPTH_W'(1);

  logic [DEPTH_W-1:0] depth_q;
  logic [PC_W-1:0]    hpc_q;
  logic               idle;
  logic               beg_take;
  logic               end_take;
  logic               err_d;

  always_comb begin
    idle           = (depth_q == '0);
    beg_take       = beg_i && !abort_i && (depth_q != DMAX);
    end_take       = end_i && !abort_i && !beg_i && !idle;
    ctl_o.take_ckpt  = beg_take && idle;
    ctl_o.commit     = end_take && (depth_q == DONE);
    ctl_o.abort_take = abort_i && !idle;
    err_d = (end_i && !abort_i && !beg_i && idle) ||
            (beg_i && !abort_i && (depth_q == DMAX));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      depth_q        <= '0;
      hpc_q          <= '0;
      redirect_vld_o <= 1'b0;
      redirect_pc_o  <= '0;
      err_o          <= 1'b0;
    end else begin
      redirect_vld_o <= ctl_o.abort_take;
      redirect_pc_o  <= hpc_q;
      err_o          <= err_d;
      if (ctl_o.take_ckpt) hpc_q <= beg_pc_i;
      if (ctl_o.abort_take)  depth_q <= '0;
      else if (beg_take)     depth_q <= depth_q + DONE;
      else if (end_take)     depth_q <= depth_q - DONE;
    end
  end

  assign depth_o = depth_q;
endmodule

// File: rtl/ckpt_rename_table.sv
module ckpt_rename_table
  import txn_ckpt_pkg::*;
#(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 64,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic                clk,
  input  logic                rst,
  input  ckpt_ctl_t           ctl_i,
  input  logic                we_i,
  input  logic [AW-1:0]       waddr_i,
  input  logic [PW-1:0]       wdata_i,
  input  logic [AW-1:0]       raddr_i,
  output logic [PW-1:0]       rdata_o,
  output logic [NUM_PHYS-1:0] mapped_o
);
  logic [PW-1:0] tbl_q  [NUM_ARCH];
  logic [PW-1:0] ckpt_q [NUM_ARCH];

  // live table and its checkpoint, one flop pair per architectural register
  for (genvar a = 0; a < NUM_ARCH; a++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        tbl_q[a]  <= PW'(a);
        ckpt_q[a] <= PW'(a);
      end else if (ctl_i.abort_take) begin
        tbl_q[a] <= ckpt_q[a];
      end else begin
        if (ctl_i.take_ckpt) ckpt_q[a] <= tbl_q[a];
        if (we_i && (waddr_i == AW'(a))) tbl_q[a] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= tbl_q[raddr_i];
  end

  // physical registers currently named by some architectural register
  always_comb begin
    mapped_o = '0;
    for (int a = 0; a < NUM_ARCH; a++) mapped_o[tbl_q[a]] = 1'b1;
  end
endmodule

// File: rtl/ckpt_preg_pool.sv
module ckpt_preg_pool
  import txn_ckpt_pkg::*;
#(
  parameter int NUM_PHYS = 64,
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic                clk,
  input  logic                rst,
  input  ckpt_ctl_t           ctl_i,
  input  logic [NUM_PHYS-1:0] mapped_i,
  input  logic                rel_i,
  input  logic [PW-1:0]       rel_preg_i,
  output logic                free_vld_o,
  output logic [PW-1:0]       free_preg_o
);
  logic [NUM_PHYS-1:0] saved_q, resv_q, drain_q;
  logic [NUM_PHYS-1:0] rel_bit, pop_bit;
  logic                rel_saved, direct, pop;
  logic [PW-1:0]       pop_idx;

  always_comb begin
    rel_bit   = rel_i ? (NUM_PHYS'(1) << rel_preg_i) : '0;
    rel_saved = rel_i && saved_q[rel_preg_i];
    direct    = rel_i && !rel_saved;
    pop_idx   = '0;
    for (int i = NUM_PHYS - 1; i >= 0; i--) begin
      if (drain_q[i]) pop_idx = PW'(i);
    end
    pop     = !direct && (drain_q != '0);
    pop_bit = pop ? (NUM_PHYS'(1) << pop_idx) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      saved_q     <= '0;
      resv_q      <= '0;
      drain_q     <= '0;
      free_vld_o  <= 1'b0;
      free_preg_o <= '0;
    end else begin
      free_vld_o  <= direct || pop;
      free_preg_o <= direct ? rel_preg_i : pop_idx;
      if (ctl_i.abort_take || ctl_i.commit) begin
        saved_q <= '0;
        resv_q  <= '0;
      end else begin
        if (ctl_i.take_ckpt) saved_q <= mapped_i;
        if (rel_saved)       resv_q  <= resv_q | rel_bit;
      end
      if (ctl_i.commit)
        drain_q <= (drain_q & ~pop_bit) | resv_q | (rel_saved ? rel_bit : '0);
      else
        drain_q <= drain_q & ~pop_bit;
    end
  end
endmodule

// File: rtl/txn_ckpt_mgr.sv
module txn_ckpt_mgr
  import txn_ckpt_pkg::*;
#(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 64,
  parameter int PC_W     = 32,
  parameter int DEPTH_W  = 3,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               xbeg_vld,
  input  logic [PC_W-1:0]    xbeg_pc,
  input  logic               xend_vld,
  input  logic               xabort_vld,
  input  logic               map_we,
  input  logic [AW-1:0]      map_waddr,
  input  logic [PW-1:0]      map_wdata,
  input  logic [AW-1:0]      map_raddr,
  output logic [PW-1:0]      map_rdata,
  input  logic               rel_vld,
  input  logic [PW-1:0]      rel_preg,
  output logic               free_vld,
  output logic [PW-1:0]      free_preg,
  output logic               redirect_vld,
  output logic [PC_W-1:0]    redirect_pc,
  output logic [DEPTH_W-1:0] nest_depth,
  output logic               nest_err
);
  ckpt_ctl_t           ctl;
  logic [NUM_PHYS-1:0] mapped;

  ckpt_nest_ctrl #(.PC_W(PC_W), .DEPTH_W(DEPTH_W)) u_nest (
    .clk(clk), .rst(rst), .beg_i(xbeg_vld), .beg_pc_i(xbeg_pc),
    .end_i(xend_vld), .abort_i(xabort_vld), .ctl_o(ctl),
    .depth_o(nest_depth), .redirect_vld_o(redirect_vld),
    .redirect_pc_o(redirect_pc), .err_o(nest_err)
  );

  ckpt_rename_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_tbl (
    .clk(clk), .rst(rst), .ctl_i(ctl), .we_i(map_we),
    .waddr_i(map_waddr), .wdata_i(map_wdata), .raddr_i(map_raddr),
    .rdata_o(map_rdata), .mapped_o(mapped)
  );

  ckpt_preg_pool #(.NUM_PHYS(NUM_PHYS)) u_pool (
    .clk(clk), .rst(rst), .ctl_i(ctl), .mapped_i(mapped),
    .rel_i(rel_vld), .rel_preg_i(rel_preg),
    .free_vld_o(free_vld), .free_preg_o(free_preg)
  );
endmodule

// File: rtl/txn_ckpt_mgr_chk.sv
module txn_ckpt_mgr_chk #(
  parameter int DEPTH_W = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               xbeg_vld,
  input logic               xend_vld,
  input logic               xabort_vld,
  input logic               redirect_vld,
  input logic [DEPTH_W-1:0] nest_depth,
  input logic               nest_err
);
  localparam logic [DEPTH_W-1:0] DMAX = '1;

  // R3
  begin_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (xbeg_vld && !xabort_vld && nest_depth != DMAX) |=>
      (nest_depth == $past(nest_depth) + 1'b1));

  // R7
  abort_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (xabort_vld && nest_depth != '0) |=> (nest_depth == '0 && redirect_vld));

  // R8
  abort_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (xabort_vld && (xbeg_vld || xend_vld) && nest_depth == '0) |=>
      (nest_depth == '0 && !nest_err));

  // R9
  end_err_chk: assert property (@(posedge clk) disable iff (rst)
    (xend_vld && !xbeg_vld && !xabort_vld && nest_depth == '0) |=>
      (nest_err && nest_depth == '0));

  // R10
  redirect_only_chk: assert property (@(posedge clk) disable iff (rst)
    !(xabort_vld && nest_depth != '0) |=> !redirect_vld);
endmodule

bind txn_ckpt_mgr txn_ckpt_mgr_chk #(.DEPTH_W(DEPTH_W)) u_chk (
  .clk(clk), .rst(rst), .xbeg_vld(xbeg_vld), .xend_vld(xend_vld),
  .xabort_vld(xabort_vld), .redirect_vld(redirect_vld),
  .nest_depth(nest_depth), .nest_err(nest_err)
);

// File: tb/tb_txn_ckpt_mgr.sv
module tb_txn_ckpt_mgr;
  localparam int NA = 32, NP = 64, PC_W = 32, DW = 3;
  localparam int AW = $clog2(NA), PW = $clog2(NP);
  localparam logic [DW-1:0] DMAX = '1;

  logic clk = 1'b0, rst = 1'b1;
  logic xbeg_vld = 0, xend_vld = 0, xabort_vld = 0, map_we = 0, rel_vld = 0;
  logic [PC_W-1:0] xbeg_pc = '0;
  logic [AW-1:0] map_waddr = '0, map_raddr = '0;
  logic [PW-1:0] map_wdata = '0, rel_preg = '0;
  logic [PW-1:0] map_rdata, free_preg;
  logic free_vld, redirect_vld, nest_err;
  logic [PC_W-1:0] redirect_pc;
  logic [DW-1:0] nest_depth;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  txn_ckpt_mgr dut (.*);

  // shadow state built from the requirements
  logic [PW-1:0] m_tbl [NA];
  logic [PW-1:0] m_ck  [NA];
  logic [NP-1:0] m_saved, m_res, m_drain;
  logic [DW-1:0] m_depth;
  logic [PC_W-1:0] m_hpc;
  logic e_rd_ok; logic [PW-1:0] e_rd;
  logic e_fv; logic [PW-1:0] e_fp;
  logic e_rv, e_err; logic [PC_W-1:0] e_rpc;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int a = 0; a < NA; a++) begin m_tbl[a] = PW'(a); m_ck[a] = PW'(a); end
    m_saved = '0; m_res = '0; m_drain = '0; m_depth = '0; m_hpc = '0;
  endtask

  function automatic int low_bit(input logic [NP-1:0] v);
    for (int i = 0; i < NP; i++) if (v[i]) return i;
    return 0;
  endfunction

  // apply inputs at a falling edge, advance the shadow, compare after the next rising edge
  task automatic cyc(input bit b, input logic [PC_W-1:0] bpc, input bit e, input bit ab,
                     input bit we, input logic [AW-1:0] wa, input logic [PW-1:0] wd,
                     input bit rl, input logic [PW-1:0] rp, input logic [AW-1:0] ra);
    bit rs, dir, abt, bt, ob, et, cm, pop;
    int idx;
    logic [NP-1:0] mp;
    xbeg_vld = b; xbeg_pc = bpc; xend_vld = e; xabort_vld = ab;
    map_we = we; map_waddr = wa; map_wdata = wd; rel_vld = rl; rel_preg = rp; map_raddr = ra;
    rs  = rl && m_saved[rp];
    dir = rl && !rs;
    abt = ab && m_depth != 0;
    bt  = b && !ab && m_depth != DMAX;
    ob  = bt && m_depth == 0;
    et  = e && !ab && !b && m_depth != 0;
    cm  = et && m_depth == 1;
    e_err = (e && !ab && !b && m_depth == 0) || (b && !ab && m_depth == DMAX);
    e_rd = m_tbl[ra]; e_rd_ok = 1;
    pop = !dir && m_drain != '0;
    idx = low_bit(m_drain);
    e_fv = dir || pop;
    e_fp = dir ? rp : PW'(idx);
    e_rv = abt; e_rpc = m_hpc;
    mp = '0;
    for (int a = 0; a < NA; a++) mp[m_tbl[a]] = 1'b1;
    if (pop) m_drain[idx] = 1'b0;
    if (cm) begin m_drain |= m_res; if (rs) m_drain[rp] = 1'b1; end
    if (abt || cm) begin m_res = '0; m_saved = '0; end
    else begin if (ob) m_saved = mp; if (rs) m_res[rp] = 1'b1; end
    if (abt) begin for (int a = 0; a < NA; a++) m_tbl[a] = m_ck[a]; end
    else begin
      if (ob) for (int a = 0; a < NA; a++) m_ck[a] = m_tbl[a];
      if (we) m_tbl[wa] = wd;
    end
    if (ob) m_hpc = bpc;
    if (abt) m_depth = '0;
    else if (bt) m_depth = m_depth + 1'b1;
    else if (et) m_depth = m_depth - 1'b1;
    @(negedge clk);
    chk(map_rdata == e_rd, "R2 read data", 64'(map_rdata), 64'(e_rd));
    chk(free_vld == e_fv, "R5 R6 push valid", 64'(free_vld), 64'(e_fv));
    if (e_fv) chk(free_preg == e_fp, "R5 R6 pushed register", 64'(free_preg), 64'(e_fp));
    chk(redirect_vld == e_rv, "R7 redirect valid", 64'(redirect_vld), 64'(e_rv));
    if (e_rv) chk(redirect_pc == e_rpc, "R7 redirect target", 64'(redirect_pc), 64'(e_rpc));
    chk(nest_err == e_err, "R4 R9 error pulse", 64'(nest_err), 64'(e_err));
    chk(nest_depth == m_depth, "R3 R4 depth", 64'(nest_depth), 64'(m_depth));
  endtask

  task automatic idle(input logic [AW-1:0] ra);
    cyc(0, '0, 0, 0, 0, '0, '0, 0, '0, ra);
  endtask

  bit done = 0;

  initial begin
    void'($urandom(32'd2718));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state and identity mapping
    chk(nest_depth == 0 && !redirect_vld && !nest_err && !free_vld, "R1 reset outputs",
        64'({nest_depth, redirect_vld, nest_err, free_vld}), 64'(0));
    for (int a = 0; a < 8; a++) begin
      idle(AW'(a));
      chk(map_rdata == PW'(a), "R1 identity map", 64'(map_rdata), 64'(a));
    end
    // R9 close at depth zero
    cyc(0, '0, 1, 0, 0, '0, '0, 0, '0, '0);
    chk(nest_err == 1'b1, "R9 unbalanced close", 64'(nest_err), 64'(1));
    // R10 abort at depth zero with an open: both ignored
    cyc(1, 32'h100, 0, 1, 0, '0, '0, 0, '0, '0);
    chk(!redirect_vld && nest_depth == 0, "R10 idle abort", 64'(redirect_vld), 64'(0));
    // R4 nest to the maximum, then one more open
    for (int i = 0; i < 7; i++) cyc(1, 32'h200 + i, 0, 0, 0, '0, '0, 0, '0, '0);
    cyc(1, 32'h300, 0, 0, 0, '0, '0, 0, '0, '0);
    chk(nest_err == 1'b1 && nest_depth == DMAX, "R4 open at maximum", 64'(nest_depth), 64'(DMAX));
    // R8 abort with a close and a table write: abort wins, write dropped
    cyc(0, '0, 1, 1, 1, AW'(3), PW'(40), 0, '0, AW'(3));
    chk(nest_depth == 0, "R8 abort priority depth", 64'(nest_depth), 64'(0));
    idle(AW'(3));
    chk(map_rdata == PW'(3), "R8 write under abort dropped", 64'(map_rdata), 64'(3));
    chk(redirect_pc == 32'h200, "R7 outermost handler", 64'(redirect_pc), 64'(32'h200));
    // R5 R6 directed: open, overwrite, release saved, commit
    cyc(1, 32'h400, 0, 0, 1, AW'(5), PW'(50), 0, '0, '0);
    cyc(0, '0, 0, 0, 0, '0, '0, 1, PW'(5), '0);
    chk(!free_vld, "R5 saved release held", 64'(free_vld), 64'(0));
    cyc(0, '0, 1, 0, 0, '0, '0, 1, PW'(45), '0);
    chk(free_vld && free_preg == PW'(45), "R5 direct release", 64'(free_preg), 64'(45));
    idle('0);
    chk(free_vld && free_preg == PW'(5), "R6 commit drain", 64'(free_preg), 64'(5));
    // random mix
    for (int n = 0; n < 6000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      cyc(r < 9, $urandom(), r >= 9 && r < 17, r >= 17 && r < 20,
          $urandom_range(0, 9) < 4, AW'($urandom()), PW'($urandom()),
          $urandom_range(0, 1) == 1, PW'($urandom()), AW'($urandom()));
    end
    repeat (80) idle(AW'($urandom()));
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule